// File: doc/BRIEF.md
# Dead-Band Phase Splitter with Kill Recovery

This block turns one pulse-width reference into two complementary phase outputs that never overlap. `phi1` follows the high level of the reference and `phi2` follows the low level. Each time the reference changes level, both phases go low. The phase that is about to become active then waits a programmable number of system clocks before it turns on. Reference intervals that are no longer than this gap leave their phase low for the whole interval.

A `kill` input forces both phases low with no clock involved. How the block comes back after `kill` depends on a two-bit recovery mode:

- Restart mode clears the internal state and waits for a fresh reference edge.
- Pass-through mode leaves the internal timing running and only masks the outputs.
- Latch-off mode shuts the block down until software toggles the enable bit.

The release of `kill` is re-timed on both clock edges. As a result, every kill pulse masks the outputs for at least half a clock cycle and at most one and a half.

Top module: `deadband_kill`

## Requirements
- R1: After a rising reference edge is registered, `phi1` stays low for `db_period` clocks and then goes high until the next edge. A falling edge does the same for `phi2`. A phase is only ever high while the registered reference is at its level.
- R2: With `db_period` = 0, `phi1` equals the reference delayed by one clock and `phi2` equals its inverse.
- R3: A reference interval of `db_period` clocks or fewer never asserts its phase. The edge that ends that interval still gives the opposite phase its full gap.
- R4: `phi1` and `phi2` are never high at the same time.
- R5: While `kill` is 1, both phases are 0 in every mode, with no clock latency.
- R6: After `kill` falls, the outputs stay masked until the first rising clock edge that follows a falling clock edge.
- R7: Recovery mode 2'b00 (restart) works as follows. While the synchronized kill is active, reference edges are ignored and the counter reloads. After release, both phases stay low until the next reference edge, which then starts a normal gap.
- R8: Recovery mode 2'b01 (pass-through) leaves the gap timing undisturbed by `kill`. Once the mask clears, the outputs show what they would have shown had no kill occurred.
- R9: Recovery modes 2'b10 and 2'b11 (latch-off) work as follows. A kill keeps both phases low, whatever the reference does, until `enable` has been low for at least one clock. Operation then resumes at the first reference edge after `enable` returns to 1.
- R10: When `rst` is 1 or `enable` is 0, both phases are 0 after the next clock. When the block leaves either state, nothing is asserted before the first reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; a low level also re-arms latch-off mode |
| pwm_ref | input | 1 | Pulse-width reference |
| kill | input | 1 | Asynchronous output kill, active high |
| db_period | input | DB_W | Gap length in clocks |
| kill_mode | input | 2 | 00 restart, 01 pass-through, 10/11 latch-off |
| phi1 | output | 1 | Phase active during the reference high level |
| phi2 | output | 1 | Phase active during the reference low level |

## Verification
A reference level applied during cycle n is registered at the following rising edge. A phase therefore turns on `db_period` edges after that one, and on at that same edge when the gap is zero. Kill masking works on a different timescale: it acts within the same cycle, and after release it lasts until the rising edge that follows the next falling edge. The bench changes inputs 5 ns after each rising edge and samples 15 ns after it, which is after the falling edge. At each rising edge it advances a behavioural model that tracks run lengths and the kill history of the last two cycles. One extra probe raises `kill` mid-cycle and samples the outputs 1 ns later to show that the mask needs no clock.

// File: rtl/dbk_pkg.sv
`timescale 1ns/1ps
package dbk_pkg;

    typedef enum logic [1:0] {
        KM_RESTART = 2'b00,
        KM_PASS    = 2'b01,
        KM_LATCH   = 2'b10,
        KM_LATCH_R = 2'b11
    } kill_mode_e;

    typedef struct packed {
        logic hi;   // phase tied to the reference high level
        logic lo;   // phase tied to the reference low level
    } phase_t;

    localparam phase_t PH_OFF = '{hi: 1'b0, lo: 1'b0};

    function automatic phase_t phase_for(input logic lvl);
        return '{hi: lvl, lo: ~lvl};
    endfunction

    function automatic logic mode_latches(input kill_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/dbk_release_sync.sv
`timescale 1ns/1ps
module dbk_release_sync (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    output logic kill_sync,
    output logic mask
);
    logic k_neg;
    logic k_pos;

    // kill sets both stages at once; release ripples fall-edge then rise-edge
    always_ff @(negedge clk or posedge kill) begin
        if (kill)     k_neg <= 1'b1;
        else if (rst) k_neg <= 1'b0;
        else          k_neg <= 1'b0;
    end

    always_ff @(posedge clk or posedge kill) begin
        if (kill)     k_pos <= 1'b1;
        else if (rst) k_pos <= 1'b0;
        else          k_pos <= k_neg;
    end

    assign kill_sync = k_pos;
    assign mask      = kill | k_neg | k_pos;

    // R6
    release_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(k_pos) |-> !kill);

endmodule

// File: rtl/dbk_core.sv
`timescale 1ns/1ps
module dbk_core
    import dbk_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            pwm_ref,
    input  logic            kill_s,
    input  kill_mode_e      mode,
    input  logic [DB_W-1:0] db_period,
    output phase_t          ph
);
    localparam logic [DB_W-1:0] CNT_ONE = DB_W'(1);

    logic            pwm_q;
    logic            hold_q;
    logic            off_q;
    logic [DB_W-1:0] cnt_q;
    phase_t          ph_q;
    logic            edge_w;

    assign edge_w = pwm_ref ^ pwm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q  <= 1'b0;
            hold_q <= 1'b1;
            off_q  <= 1'b0;
            cnt_q  <= db_period;
            ph_q   <= PH_OFF;
        end else if (!enable || off_q) begin
            pwm_q  <= pwm_ref;
            hold_q <= 1'b1;
            off_q  <= off_q & enable;
            cnt_q  <= db_period;
            ph_q   <= PH_OFF;
        end else if (kill_s && mode != KM_PASS) begin
            pwm_q  <= pwm_ref;
            hold_q <= 1'b1;
            off_q  <= mode_latches(mode);
            cnt_q  <= db_period;
            ph_q   <= PH_OFF;
        end else begin
            pwm_q <= pwm_ref;
            if (edge_w) begin
                hold_q <= 1'b0;
                cnt_q  <= db_period;
                ph_q   <= (db_period == '0) ? phase_for(pwm_ref) : PH_OFF;
            end else if (hold_q) begin
                cnt_q <= db_period;
                ph_q  <= PH_OFF;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_ONE;
                if (cnt_q == CNT_ONE) ph_q <= phase_for(pwm_ref);
            end
        end
    end

    assign ph = ph_q;

    // R4
    phase_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(ph_q.hi && ph_q.lo));

    // R1
    hi_level_chk: assert property (@(posedge clk) disable iff (rst)
        ph_q.hi |-> pwm_q);

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (ph_q == PH_OFF));

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (off_q && enable) |=> off_q);

    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && kill_s && mode == KM_RESTART) |=> (hold_q && ph_q == PH_OFF));

endmodule

// File: rtl/deadband_kill.sv
`timescale 1ns/1ps
module deadband_kill
    import dbk_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            pwm_ref,
    input  logic            kill,
    input  logic [DB_W-1:0] db_period,
    input  logic [1:0]      kill_mode,
    output logic            phi1,
    output logic            phi2
);
    logic   kill_sync;
    logic   mask;
    phase_t ph;

    dbk_release_sync u_rel (
        .clk       (clk),
        .rst       (rst),
        .kill      (kill),
        .kill_sync (kill_sync),
        .mask      (mask)
    );

    dbk_core #(.DB_W(DB_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .pwm_ref   (pwm_ref),
        .kill_s    (kill_sync),
        .mode      (kill_mode_e'(kill_mode)),
        .db_period (db_period),
        .ph        (ph)
    );

    assign phi1 = ph.hi & ~mask;
    assign phi2 = ph.lo & ~mask;

    // R5
    kill_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
        kill |-> (!phi1 && !phi2));

endmodule

// File: tb/deadband_kill_tb.sv
`timescale 1ns/1ps
module deadband_kill_tb;
    localparam int DB_W = 8;

    logic            clk = 1'b0;
    logic            rst, enable, pwm_ref, kill;
    logic [DB_W-1:0] db_period;
    logic [1:0]      kill_mode;
    logic            phi1, phi2;

    deadband_kill #(.DB_W(DB_W)) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .pwm_ref(pwm_ref), .kill(kill),
        .db_period(db_period), .kill_mode(kill_mode), .phi1(phi1), .phi2(phi2)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";

    // next-cycle stimulus, currently applied stimulus, previous kill level
    logic n_rst = 1, n_en = 0, n_pwm = 0, n_kill = 0;
    logic [1:0] n_mode = 2'b01;
    int   n_db = 2;
    logic c_rst = 1, c_en = 0, c_pwm = 0, c_kill = 0, p_kill = 0;
    logic [1:0] c_mode = 2'b01;
    int   c_db = 2;

    // behavioural model state
    logic m_hold = 1, m_off = 0, m_prev = 0, m_p1 = 0, m_p2 = 0;
    int   m_run = 0;

    initial begin
        rst = 1; enable = 0; pwm_ref = 0; kill = 0; db_period = 2; kill_mode = 2'b01;
    end

    task automatic model_step();
        logic ks;
        logic edg;
        ks = c_kill | p_kill;
        if (c_rst) begin
            m_hold = 1; m_off = 0; m_prev = 0; m_p1 = 0; m_p2 = 0;
        end else if (!c_en || m_off) begin
            if (!c_en) m_off = 0;
            m_hold = 1; m_prev = c_pwm; m_p1 = 0; m_p2 = 0;
        end else if (ks && c_mode != 2'b01) begin
            if (c_mode[1]) m_off = 1;
            m_hold = 1; m_prev = c_pwm; m_p1 = 0; m_p2 = 0;
        end else begin
            edg = (c_pwm != m_prev);
            m_prev = c_pwm;
            if (m_hold && edg) begin
                m_hold = 0; m_run = 1;
            end else if (!m_hold) begin
                m_run = edg ? 1 : m_run + 1;
            end
            if (m_hold) begin
                m_p1 = 0; m_p2 = 0;
            end else begin
                m_p1 = c_pwm  && (m_run >= c_db + 1);
                m_p2 = !c_pwm && (m_run >= c_db + 1);
            end
        end
    endtask

    task automatic compare();
        logic e1, e2;
        string tag;
        e1 = m_p1 & !(c_kill | p_kill);
        e2 = m_p2 & !(c_kill | p_kill);
        if (c_kill)      tag = "R5";
        else if (p_kill) tag = "R6";
        else             tag = cur_req;
        checks++;
        if (phi1 !== e1 || phi2 !== e2) begin
            errors++;
            $display("FAIL %s at %0t: phi1/phi2=%b%b expected %b%b", tag, $time, phi1, phi2, e1, e2);
        end
        checks++;
        if (phi1 === 1'b1 && phi2 === 1'b1) begin
            errors++;
            $display("FAIL R4 at %0t: phi1/phi2=%b%b expected not both high", $time, phi1, phi2);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            #5;
            p_kill = c_kill;
            c_rst = n_rst; c_en = n_en; c_pwm = n_pwm; c_kill = n_kill;
            c_mode = n_mode; c_db = n_db;
            rst = c_rst; enable = c_en; pwm_ref = c_pwm; kill = c_kill;
            kill_mode = c_mode; db_period = DB_W'(c_db);
            #10;
            compare();
        end
    endtask

    // raise kill mid-cycle and look 1 ns later: no clock involved (R5)
    task automatic kill_now();
        #1;
        kill = 1'b1; c_kill = 1'b1; n_kill = 1'b1;
        #1;
        checks++;
        if (phi1 !== 1'b0 || phi2 !== 1'b0) begin
            errors++;
            $display("FAIL R5 at %0t: phi1/phi2=%b%b expected 00 right after kill", $time, phi1, phi2);
        end
    endtask

    task automatic pwm_run(input int hi, input int lo, input int periods);
        for (int p = 0; p < periods; p++) begin
            n_pwm = 1; cyc(hi);
            n_pwm = 0; cyc(lo);
        end
    endtask

    task automatic reconfig(input int db, input logic [1:0] mode);
        n_en = 0; cyc(1);
        n_db = db; n_mode = mode; cyc(1);
        n_en = 1;
    endtask

    initial begin
        cur_req = "R10";
        cyc(3);
        n_rst = 0; cyc(2);
        n_en = 1; cyc(3);           // enabled, no edge yet: stays quiet

        cur_req = "R1";
        reconfig(3, 2'b01);
        pwm_run(8, 8, 3);

        cur_req = "R2";
        reconfig(0, 2'b01);
        pwm_run(3, 5, 2);
        pwm_run(1, 1, 3);

        cur_req = "R3";
        reconfig(2, 2'b01);
        pwm_run(5, 2, 2);
        pwm_run(6, 1, 1);
        pwm_run(2, 6, 2);
        pwm_run(3, 3, 1);

        cur_req = "R8";
        reconfig(2, 2'b01);
        pwm_run(6, 6, 1);
        n_pwm = 1; cyc(5);
        kill_now(); cyc(2);
        n_kill = 0; cyc(4);
        n_pwm = 0; cyc(2);
        kill_now(); n_kill = 0; cyc(6);

        cur_req = "R7";
        reconfig(2, 2'b00);
        pwm_run(6, 6, 1);
        n_pwm = 1; cyc(5);
        kill_now(); n_kill = 0; cyc(4);
        n_pwm = 0; cyc(6);
        n_pwm = 1; cyc(3);
        kill_now(); cyc(1);
        n_pwm = 0; cyc(3);          // edge during kill ignored
        n_kill = 0; cyc(4);
        pwm_run(6, 6, 1);

        cur_req = "R9";
        reconfig(1, 2'b10);
        pwm_run(5, 5, 1);
        n_pwm = 1; cyc(3);
        kill_now(); n_kill = 0; cyc(2);
        n_pwm = 0; cyc(5);
        pwm_run(4, 4, 1);
        n_en = 0; cyc(1);
        n_en = 1; cyc(3);
        pwm_run(4, 4, 2);
        reconfig(1, 2'b11);
        pwm_run(4, 4, 1);
        n_pwm = 1; cyc(2);
        kill_now(); n_kill = 0; cyc(1);
        pwm_run(4, 4, 1);
        n_en = 0; cyc(2);
        n_en = 1; pwm_run(4, 4, 2);

        cur_req = "R10";
        n_en = 0; n_pwm = 1; cyc(4);
        n_en = 1; cyc(3);
        n_rst = 1; cyc(2);
        n_rst = 0; pwm_run(4, 4, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        checks++;
        errors++;
        $display("FAIL watchdog at %0t: run did not complete (all requirements)", $time);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule